// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a 128-bit SIMD multiply datapath. It splits both operands into eight 16-bit lanes and computes every lane in parallel in one of two modes. A one-bit mode select picks the mode. The result is registered and appears one clock after a valid strobe.

In byte dot-product mode, each 16-bit lane holds two byte pairs. The bytes of operand A are read as unsigned values and the bytes of operand B as signed values. The two products in a lane are added, and the sum is clamped to the signed 16-bit range.

In fixed-point mode, each lane is a signed 16-bit number. The lanes are multiplied, and the product is scaled back to Q15 with round-half-up. Q15 code, such as filter taps and gain stages, uses this mode to keep results in the same format as its inputs.

Top module: `pmul_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid is cleared to 0 and result is cleared to all zeros at that edge.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: When in_valid is low, result keeps its previous value whatever the operands and mode are.
- R4: With mode = 0 (byte dot-product), result lane k (bits 16k+15..16k) is A[2k]*B[2k] + A[2k+1]*B[2k+1]. Byte j occupies bits 8j+7..8j. Bytes of opa are unsigned and bytes of opb are two's-complement signed.
- R5: In mode 0, a lane sum above 32767 gives 16'h7FFF.
- R6: In mode 0, a lane sum below -32768 gives 16'h8000.
- R7: With mode = 1 (fixed-point), each signed 16-bit lane pair forms a 32-bit product p. The lane result is bits 16..1 of (p >>> 14) + 1, which is round-half-up of p / 2^15.
- R8: In mode 1, the lane pair 16'h8000 times 16'h8000 gives 16'h8000, because the result wraps and is not clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The operands and mode are presented this cycle |
| mode | input | 1 | 0 = byte dot-product with saturation, 1 = rounded Q15 multiply |
| opa | input | 128 | Operand A (unsigned bytes in mode 0, signed words in mode 1) |
| opb | input | 128 | Operand B (signed bytes in mode 0, signed words in mode 1) |
| out_valid | output | 1 | result holds a fresh value |
| result | output | 128 | Eight 16-bit result lanes, registered |

## Verification
The dot-product mode is tried with the following patterns:
- All-ones A against the largest positive B and against the most negative B. These show that the clamp acts on both sides.
- All-ones A against B = -1. This tells a signed reading of B from an unsigned one.
- A single lane loaded with distinct byte values. This catches swapped byte pairs and a lane landing at the wrong position.
- A mixed word pattern. This covers the general case.

The fixed-point mode is tried with the following patterns:
- Half-scale by half-scale, which has an exact known answer.
- The most negative value squared, which must wrap.
- A mixed pattern of extremes, odd values and negative values, which exposes errors in the rounding bit and in sign extension.

Idle cycles with changed operands show that the output register holds and that the valid flag drops.

// File: rtl/pmul_pkg.sv
// Package: shared constants and the mode encoding of the packed multiply unit.
// Assumes the lane width is twice the byte width.
package pmul_pkg;
    localparam int BYTE_W = 8;
    localparam int LANE_W = 2 * BYTE_W;

    typedef enum logic {
        MODE_DOT  = 1'b0,
        MODE_Q15  = 1'b1
    } pmul_mode_e;
endpackage

// File: rtl/pmul_dot_lane.sv
// Module: pmul_dot_lane
// Forms one 16-bit lane of the byte dot-product: two unsigned-by-signed byte
// products are summed at full width and then clamped to the signed lane range.
// Assumes: purely combinational; byte 0 sits in the low half of each input.
module pmul_dot_lane #(
    parameter int BW = 8
) (
    input  logic [2*BW-1:0] a_in,
    input  logic [2*BW-1:0] b_in,
    output logic [2*BW-1:0] sum_out
);
    localparam int PW = 2 * BW + 1;   // width of one mixed-sign product
    localparam int SW = 2 * BW + 2;   // width of the unclamped sum

    localparam logic signed [SW-1:0] HI_LIM = {3'b000, {(2*BW-1){1'b1}}};
    localparam logic signed [SW-1:0] LO_LIM = {3'b111, {(2*BW-1){1'b0}}};

    logic signed [PW-1:0] prod_lo;
    logic signed [PW-1:0] prod_hi;
    logic signed [SW-1:0] wide_sum;

    // Mixed-sign products, with A zero-extended so it stays non-negative.
    always_comb begin
        prod_lo = $signed({1'b0, a_in[BW-1:0]})    * $signed(b_in[BW-1:0]);
        prod_hi = $signed({1'b0, a_in[2*BW-1:BW]}) * $signed(b_in[2*BW-1:BW]);
        wide_sum = SW'(prod_lo) + SW'(prod_hi);
    end

    // Clamp the full-width sum to the signed lane range.
    always_comb begin
        if (wide_sum > HI_LIM) begin
            sum_out = {1'b0, {(2*BW-1){1'b1}}};
        end else if (wide_sum < LO_LIM) begin
            sum_out = {1'b1, {(2*BW-1){1'b0}}};
        end else begin
            sum_out = wide_sum[2*BW-1:0];
        end
    end
endmodule

// File: rtl/pmul_q15_lane.sv
// Module: pmul_q15_lane
// Forms one lane of the rounded fixed-point multiply. The full signed product
// keeps its top W+2 bits, gains one, and bits W..1 of that value are the result.
// Assumes: purely combinational; the wrap for the most negative square is intended.
module pmul_q15_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] prod_out
);
    localparam int PW = 2 * W;     // full product width
    localparam int TW = W + 2;     // bits kept after the scaling shift

    logic signed [PW-1:0] full_prod;
    logic        [TW-1:0] top_bits;
    logic        [TW-1:0] rounded;

    // Full-precision signed product, then the scale and round steps.
    always_comb begin
        full_prod = $signed(a_in) * $signed(b_in);
        top_bits  = full_prod[PW-1:W-2];
        rounded   = top_bits + {{(TW-1){1'b0}}, 1'b1};
        prod_out  = rounded[W:1];
    end
endmodule

// File: rtl/pmul_unit.sv
// Module: pmul_unit (top)
// Packed multiply unit. It computes eight lanes in parallel in the mode that
// `mode` selects and registers the result. The result register loads only on
// in_valid; out_valid follows in_valid by one cycle.
// Assumes: synchronous active-low reset; operands are stable only in the cycle
// that in_valid marks.
module pmul_unit #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import pmul_pkg::*;

    localparam int LW    = LANE_W;
    localparam int LANES = DATA_W / LW;

    logic [DATA_W-1:0] dot_vec;
    logic [DATA_W-1:0] q15_vec;
    logic [DATA_W-1:0] next_vec;
    pmul_mode_e        mode_sel;

    assign mode_sel = pmul_mode_e'(mode);

    // One pair of lane engines per 16-bit lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pmul_dot_lane #(.BW(BYTE_W)) u_dot (
            .a_in    (opa[k*LW +: LW]),
            .b_in    (opb[k*LW +: LW]),
            .sum_out (dot_vec[k*LW +: LW])
        );
        pmul_q15_lane #(.W(LW)) u_q15 (
            .a_in     (opa[k*LW +: LW]),
            .b_in     (opb[k*LW +: LW]),
            .prod_out (q15_vec[k*LW +: LW])
        );
    end

    // Pick the engine the mode asks for.
    always_comb begin
        next_vec = (mode_sel == MODE_Q15) ? q15_vec : dot_vec;
    end

    // Result register: loads on in_valid and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_vec;
        end
    end

    // Valid flag: in_valid delayed by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end
endmodule

// File: rtl/pmul_unit_chk.sv
// Module: pmul_unit_chk
// Temporal properties of pmul_unit, attached to every instance by the bind below.
// Assumes: the port names match those of pmul_unit.
module pmul_unit_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    // R1: a reset edge clears the valid flag and the result.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R2: valid follows the strobe by one cycle.
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: an idle cycle leaves the result unchanged.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R4: all-zero signed bytes give an all-zero dot-product.
    p_zero_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && opb == '0) |=> result == '0);

    // R7: a zero multiplier rounds to zero in fixed-point mode.
    p_zero_mult_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && opb == '0) |=> result == '0);

    // Touch the operand A port so that every checker input is used.
    logic unused_opa;
    assign unused_opa = ^opa;
endmodule

bind pmul_unit pmul_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pmul_unit.sv
// Bench for pmul_unit: a table walk followed by directed reset, lane and hold tests.
module sim_pmul_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    // Each vector holds {mode, opa, opb}.
    localparam logic [256:0] VEC [8] = '{
        {1'b0, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 128'h7F80_FF01_10F0_2040_8181_7F7F_0000_C3A5},
        {1'b0, {16{8'hFF}}, {16{8'h7F}}},
        {1'b0, {16{8'hFF}}, {16{8'h80}}},
        {1'b0, {16{8'h01}}, {16{8'hFF}}},
        {1'b1, {8{16'h8000}}, {8{16'h8000}}},
        {1'b1, {8{16'h4000}}, {8{16'h4000}}},
        {1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h7FFF_8000_0001_FFFF_1234_5678_9ABC_DEF0},
        {1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h7FFF_8000_0001_FFFF_1234_5678_9ABC_DEF0}
    };
    localparam string VEC_REQ [8] = '{"R4", "R5", "R6", "R4", "R8", "R7", "R7", "R4"};

    // Expected result of the dot-product mode, from R4..R6.
    function automatic logic [127:0] ref_dot(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        for (int k = 0; k < 8; k++) begin
            int s;
            s = int'(a[16*k +: 8]) * int'($signed(b[16*k +: 8]))
              + int'(a[16*k+8 +: 8]) * int'($signed(b[16*k+8 +: 8]));
            if (s > 32767)  s = 32767;
            if (s < -32768) s = -32768;
            r[16*k +: 16] = 16'(s);
        end
        return r;
    endfunction

    // Expected result of the fixed-point mode, from R7 and R8.
    function automatic logic [127:0] ref_q15(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        for (int k = 0; k < 8; k++) begin
            longint p;
            longint t;
            p = longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
            t = (p >>> 14) + 1;
            r[16*k +: 16] = 16'(t >>> 1);
        end
        return r;
    endfunction

    task automatic check_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Present one operation for a single cycle; return at the negedge where it shows.
    task automatic issue(input logic m, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        mode = m; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        check_bit("R1 out_valid", out_valid, 1'b0);
        check_vec("R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            logic         m;
            logic [127:0] a;
            logic [127:0] b;
            logic [127:0] exp;
            {m, a, b} = VEC[i];
            exp = m ? ref_q15(a, b) : ref_dot(a, b);
            issue(m, a, b);
            check_vec(VEC_REQ[i], result, exp);
            check_bit("R2 valid high", out_valid, 1'b1);
        end

        // R4: lane 1 alone: 3*5 + 2*(-1) = 13, other lanes 0
        issue(1'b0, 128'h0000_0000_0000_0000_0000_0000_0203_0000,
                    128'h0000_0000_0000_0000_0000_0000_FF05_0000);
        check_vec("R4 lane position", result, 128'h0000_0000_0000_0000_0000_0000_000D_0000);

        // R7: 0x4000 * 0x4000 in one lane gives 0x2000
        issue(1'b1, {8{16'h4000}}, {8{16'h4000}});
        check_vec("R7 half scale", result, {8{16'h2000}});

        // R3 / R2: idle cycles with new operands leave the result alone
        @(negedge clk);
        mode = 1'b0; opa = {16{8'hFF}}; opb = {16{8'h7F}};
        check_bit("R2 valid low", out_valid, 1'b0);
        @(negedge clk);
        check_vec("R3 hold", result, {8{16'h2000}});
        mode = 1'b1;
        @(negedge clk);
        check_vec("R3 hold mode change", result, {8{16'h2000}});

        // R1: a reset in mid-run clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R1 mid reset", result, '0);
        check_bit("R1 mid reset valid", out_valid, 1'b0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule